// File: doc/BRIEF.md
# Zero-Overhead Repeat Controller

This block steers the fetch address of a simple in-order sequencer so that a loop body runs a set number of times without any branch instruction. A repeat command carries an extra-iteration count and selects one of two body shapes: the single instruction directly after the command, or a block of instructions bounded by a start and an end address. Accepting a command asks the pipeline for one flush and redirects fetch to the body start. From then on a dedicated down-counter and two bound registers send fetch back to the start each time the end address is fetched. There is no per-iteration cost.

The sequencer presents the current fetch address and an advance strobe every cycle. It takes `nxt_pc_o` as the address to fetch next. While the repeat command is presented, `fetch_pc_i` holds that command's own address. All outputs are combinational from the registered loop state and the present inputs. State changes on the rising clock edge.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset `active_o`, `flush_o` and `err_o` are 0. With no loop active, `nxt_pc_o` is `fetch_pc_i`+1 when `fetch_adv_i` is 1 and `fetch_pc_i` when it is 0.
- R2: A repeat command (`rpt_i`=1) accepted while no loop is active drives `flush_o` to 1 in that cycle only, sets `nxt_pc_o` to the body start, and raises `active_o` from the next cycle.
- R3: With `rpt_block_i`=0 (single mode), the body start and end are both `fetch_pc_i`+1 of the command cycle. `blk_start_i` and `blk_end_i` are ignored.
- R4: With `rpt_block_i`=1 (block mode), the body covers `blk_start_i` through `blk_end_i`. Every address fetched while the loop runs lies in that range.
- R5: A count operand of N makes the body run N+1 times, so a body of L instructions takes (N+1)*L fetch advances. A count of 0 runs it once.
- R6: An advance at the end address with the counter nonzero sets `nxt_pc_o` to the body start and decrements the counter. No flush is requested on any iteration.
- R7: An advance at the end address with the counter at zero sets `nxt_pc_o` to end+1 and clears `active_o` from the next cycle.
- R8: Inside a loop, an advance at any address other than the end moves `nxt_pc_o` to `fetch_pc_i`+1. A cycle with `fetch_adv_i`=0 gives `nxt_pc_o`=`fetch_pc_i` and leaves the count unchanged.
- R9: A repeat command while a loop is active gives no flush and leaves the running loop unchanged. It sets `err_o`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rpt_i | input | 1 | Repeat command present this cycle |
| rpt_block_i | input | 1 | 1 = block body, 0 = single following instruction |
| rpt_count_i | input | CW | Extra iterations (body runs count+1 times) |
| blk_start_i | input | AW | First address of a block body |
| blk_end_i | input | AW | Last address of a block body |
| fetch_pc_i | input | AW | Current fetch address |
| fetch_adv_i | input | 1 | Fetch advances this cycle |
| nxt_pc_o | output | AW | Address to fetch next |
| active_o | output | 1 | A loop is running |
| flush_o | output | 1 | One-cycle pipeline flush request on loop setup |
| err_o | output | 1 | Sticky flag: repeat command arrived while a loop was active |

## Verification
The vector table drives whole loops through a fetch model. It covers single mode with count 0, a middle count and the largest count. It also covers block mode with a one-instruction block, short and long blocks, and a block placed away from the command. Comparing total fetches, exit address and flush count separates an off-by-one in the counter from a wrong wrap target and from a wrong exit address. Two rows add a stall at the end address and a second repeat command inside the loop. These show whether stalls consume iterations and whether a rejected command disturbs the loop in progress.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;
  typedef enum logic [2:0] {
    SEL_HOLD,
    SEL_INC,
    SEL_LOAD,
    SEL_WRAP,
    SEL_EXIT
  } nxt_sel_e;
endpackage

// File: rtl/hwloop_cnt.sv
module hwloop_cnt #(
  parameter int CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  input  logic          dec_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/hwloop_addr.sv
module hwloop_addr #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          block_i,
  input  logic [AW-1:0] start_i,
  input  logic [AW-1:0] end_i,
  input  logic [AW-1:0] fetch_pc_i,
  output logic [AW-1:0] load_start_o,
  output logic [AW-1:0] start_q_o,
  output logic [AW-1:0] end_q_o,
  output logic          at_end_o
);
  logic [AW-1:0] after_cmd;
  logic [AW-1:0] load_end;

  assign after_cmd    = fetch_pc_i + 1'b1;
  // single mode: body is the instruction right after the command
  assign load_start_o = block_i ? start_i : after_cmd;
  assign load_end     = block_i ? end_i   : after_cmd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q_o <= '0;
      end_q_o   <= '0;
    end else if (load_i) begin
      start_q_o <= load_start_o;
      end_q_o   <= load_end;
    end
  end

  assign at_end_o = (fetch_pc_i == end_q_o);
endmodule

// File: rtl/hwloop_nextpc.sv
module hwloop_nextpc
  import hwloop_pkg::*;
#(
  parameter int AW = 16
) (
  input  nxt_sel_e      sel_i,
  input  logic [AW-1:0] fetch_pc_i,
  input  logic [AW-1:0] load_start_i,
  input  logic [AW-1:0] start_q_i,
  input  logic [AW-1:0] end_q_i,
  output logic [AW-1:0] nxt_pc_o
);
  always_comb begin
    unique case (sel_i)
      SEL_INC:  nxt_pc_o = fetch_pc_i + 1'b1;
      SEL_LOAD: nxt_pc_o = load_start_i;
      SEL_WRAP: nxt_pc_o = start_q_i;
      SEL_EXIT: nxt_pc_o = end_q_i + 1'b1;
      default:  nxt_pc_o = fetch_pc_i;
    endcase
  end
endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
  import hwloop_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rpt_i,
  input  logic          rpt_block_i,
  input  logic [CW-1:0] rpt_count_i,
  input  logic [AW-1:0] blk_start_i,
  input  logic [AW-1:0] blk_end_i,
  input  logic [AW-1:0] fetch_pc_i,
  input  logic          fetch_adv_i,
  output logic [AW-1:0] nxt_pc_o,
  output logic          active_o,
  output logic          flush_o,
  output logic          err_o
);
  logic          active_q, err_q;
  logic          accept, wrap, leave;
  logic          at_end, cnt_zero;
  logic [AW-1:0] load_start, start_q, end_q;
  nxt_sel_e      sel;

  assign accept = rpt_i & ~active_q;
  assign wrap   = active_q & fetch_adv_i & at_end & ~cnt_zero;
  assign leave  = active_q & fetch_adv_i & at_end & cnt_zero;

  always_comb begin
    if (accept)           sel = SEL_LOAD;
    else if (wrap)        sel = SEL_WRAP;
    else if (leave)       sel = SEL_EXIT;
    else if (fetch_adv_i) sel = SEL_INC;
    else                  sel = SEL_HOLD;
  end

  hwloop_cnt #(.CW(CW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .val_i  (rpt_count_i),
    .dec_i  (wrap),
    .zero_o (cnt_zero)
  );

  hwloop_addr #(.AW(AW)) u_addr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (accept),
    .block_i      (rpt_block_i),
    .start_i      (blk_start_i),
    .end_i        (blk_end_i),
    .fetch_pc_i   (fetch_pc_i),
    .load_start_o (load_start),
    .start_q_o    (start_q),
    .end_q_o      (end_q),
    .at_end_o     (at_end)
  );

  hwloop_nextpc #(.AW(AW)) u_nxt (
    .sel_i        (sel),
    .fetch_pc_i   (fetch_pc_i),
    .load_start_i (load_start),
    .start_q_i    (start_q),
    .end_q_i      (end_q),
    .nxt_pc_o     (nxt_pc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (accept)     active_q <= 1'b1;
      else if (leave) active_q <= 1'b0;
      if (rpt_i && active_q) err_q <= 1'b1;
    end
  end

  assign active_o = active_q;
  assign flush_o  = accept;
  assign err_o    = err_q;
endmodule

// File: rtl/hwloop_ctrl_chk.sv
module hwloop_ctrl_chk #(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rpt_i,
  input logic          rpt_block_i,
  input logic [AW-1:0] fetch_pc_i,
  input logic          fetch_adv_i,
  input logic [AW-1:0] nxt_pc_o,
  input logic          active_o,
  input logic          flush_o,
  input logic          err_o
);
  a_r2_flush_starts_loop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> active_o);

  a_r3_single_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_o && !rpt_block_i) |-> (nxt_pc_o == fetch_pc_i + 1'b1));

  a_r6_no_flush_in_loop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !rpt_i) |-> !flush_o);

  a_r7_exit_on_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) |-> $past(fetch_adv_i));

  a_r8_stall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !fetch_adv_i && !rpt_i) |-> (nxt_pc_o == fetch_pc_i));

  a_r9_err_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_i && active_o) |=> err_o);

  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  a_r9_no_flush_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_i && active_o) |-> !flush_o);
endmodule

bind hwloop_ctrl hwloop_ctrl_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rpt_i       (rpt_i),
  .rpt_block_i (rpt_block_i),
  .fetch_pc_i  (fetch_pc_i),
  .fetch_adv_i (fetch_adv_i),
  .nxt_pc_o    (nxt_pc_o),
  .active_o    (active_o),
  .flush_o     (flush_o),
  .err_o       (err_o)
);

// File: tb/sim_hwloop_ctrl.sv
module sim_hwloop_ctrl;
  localparam int CLK_P = 10;
  localparam int AW = 16;
  localparam int CW = 10;
  localparam int NV = 9;
  localparam logic [AW-1:0] CMD_PC = 16'h0100;

  // table: block mode, count, start, end, stall at end once, second command inside loop
  localparam int V_BLK [NV] = '{0, 0, 0, 1, 1, 1, 1, 1, 1};
  localparam int V_CNT [NV] = '{0, 5, 1023, 0, 3, 2, 1, 2, 4};
  localparam int V_S   [NV] = '{0, 0, 0, 'h101, 'h101, 'h200, 'h101, 'h101, 'h101};
  localparam int V_E   [NV] = '{0, 0, 0, 'h101, 'h104, 'h20F, 'h180, 'h103, 'h102};
  localparam int V_STL [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 0};
  localparam int V_INJ [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rpt = 1'b0;
  logic          rpt_block = 1'b0;
  logic [CW-1:0] rpt_count = '0;
  logic [AW-1:0] blk_start = '0;
  logic [AW-1:0] blk_end = '0;
  logic [AW-1:0] fetch_pc = '0;
  logic          fetch_adv = 1'b0;
  logic [AW-1:0] nxt_pc;
  logic          active, flush, err;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  hwloop_ctrl #(.AW(AW), .CW(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rpt_i(rpt), .rpt_block_i(rpt_block),
    .rpt_count_i(rpt_count), .blk_start_i(blk_start), .blk_end_i(blk_end),
    .fetch_pc_i(fetch_pc), .fetch_adv_i(fetch_adv),
    .nxt_pc_o(nxt_pc), .active_o(active), .flush_o(flush), .err_o(err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic edge_step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_loop(input int blk, input int cnt, input int s, input int e,
                          input int stall, input int inj);
    int exp_s, exp_e, len, fetches, flushes, outside;
    logic [AW-1:0] pc;
    bit stalled, injected;
    exp_s = blk ? s : int'(CMD_PC) + 1;
    exp_e = blk ? e : int'(CMD_PC) + 1;
    len = exp_e - exp_s + 1;
    rpt = 1'b1; rpt_block = blk[0]; rpt_count = CW'(cnt);
    blk_start = AW'(s); blk_end = AW'(e);
    fetch_pc = CMD_PC; fetch_adv = 1'b1;
    #1;
    chk("R2 setup flush", int'(flush), 1);
    chk(blk ? "R4 block start" : "R3 single start", int'(nxt_pc), exp_s);
    pc = nxt_pc;
    edge_step();
    rpt = 1'b0;
    blk_start = 16'hDEAD; blk_end = 16'hBEEF;
    chk("R2 active after setup", int'(active), 1);
    fetches = 0; flushes = 0; outside = 0; stalled = 0; injected = 0;
    for (int k = 0; k < 5000; k++) begin
      fetch_pc = pc;
      if (stall != 0 && !stalled && int'(pc) == exp_e) begin
        stalled = 1;
        fetch_adv = 1'b0;
        #1;
        chk("R8 stall holds address", int'(nxt_pc), int'(pc));
        edge_step();
        chk("R8 stall keeps loop", int'(active), 1);
        fetch_adv = 1'b1;
        fetch_pc = pc;
      end
      if (inj != 0 && !injected) begin
        injected = 1;
        rpt = 1'b1; rpt_block = 1'b1; rpt_count = CW'(7);
        blk_start = 16'h0300; blk_end = 16'h0305;
        #1;
        chk("R9 no flush while active", int'(flush), 0);
      end else begin
        #1;
      end
      fetches++;
      flushes += int'(flush);
      if (int'(pc) < exp_s || int'(pc) > exp_e) outside++;
      pc = nxt_pc;
      edge_step();
      if (rpt) begin
        rpt = 1'b0;
        chk("R9 err set", int'(err), 1);
      end
      if (!active) break;
    end
    chk("R5 fetch count", fetches, (cnt + 1) * len);
    chk("R7 exit address", int'(pc), exp_e + 1);
    chk("R6 no flush per iteration", flushes, 0);
    chk("R4 fetches inside body", outside, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset active", int'(active), 0);
    chk("R1 reset err", int'(err), 0);
    rst_n = 1'b1;
    edge_step();
    fetch_pc = 16'h0005; fetch_adv = 1'b1;
    #1;
    chk("R1 idle advance", int'(nxt_pc), 6);
    chk("R1 idle no flush", int'(flush), 0);
    fetch_adv = 1'b0;
    #1;
    chk("R1 idle hold", int'(nxt_pc), 5);
    edge_step();

    for (int v = 0; v < NV; v++) begin
      run_loop(V_BLK[v], V_CNT[v], V_S[v], V_E[v], V_STL[v], V_INJ[v]);
      edge_step();
    end

    // the error flag stays set across idle cycles
    fetch_adv = 1'b1; fetch_pc = 16'h0040;
    repeat (3) edge_step();
    chk("R9 err sticky", int'(err), 1);
    chk("R7 idle after loops", int'(active), 0);

    rst_n = 1'b0;
    #1;
    chk("R1 reset clears err", int'(err), 0);
    edge_step();
    rst_n = 1'b1;
    edge_step();

    // count zero in block mode after reset: body once, then leaves
    run_loop(1, 0, 'h110, 'h113, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule